// File: doc/BRIEF.md
# Instruction-Driven FIFO Queue Ports

This block connects an instruction-execution stage directly to two external synchronous FIFOs through point-to-point handshake ports. There is no system bus and no address decoding. A transfer starts when the instruction that names the queue issues. A push-issue pulse sends a word toward the outbound FIFO. That word is either the instruction's first operand or a value computed from the operands in the same instruction. A pop-issue pulse takes a word from the inbound FIFO into a result register.

The outbound side has three signals: a full input, a push-request output and a data output. The inbound side also has three: an empty input, a pop-request output and a data input. When the FIFOs are ready, each direction moves one word per clock cycle. When the outbound FIFO is full, or the inbound FIFO is empty, the block raises a stall toward the issuing pipeline. It keeps the pending transfer until the handshake can complete.

Each direction has its own two-state machine.

The push side has these states and transitions:
- PUSH_IDLE goes to PUSH_HELD when a push issues.
- PUSH_HELD stays in PUSH_HELD while full is high.
- PUSH_HELD also stays in PUSH_HELD when full is low and a new push issues in the same cycle.
- PUSH_HELD returns to PUSH_IDLE when full is low and no push issues.

The pop side has these states and transitions:
- POP_IDLE stays in POP_IDLE on an issue that pops at once, because empty is low.
- POP_IDLE goes to POP_WAIT on an issue while empty is high.
- POP_WAIT stays in POP_WAIT while empty is high.
- POP_WAIT returns to POP_IDLE on the cycle it pops.

Top module: `qport_bridge`

## Requirements
- R1: The pushed value is selected by `push_fn`:
  - 0 gives `push_opa`.
  - 1 gives the W+1-bit sum `push_opa + push_opb` shifted right by one.
  - 2 gives `push_opa` with its lowest set bit cleared (zero stays zero).
  - 3 gives the number of set bits in `push_opa`.
- R2: A push accepted at a clock edge appears on `oq_data` in the next cycle. In that cycle `oq_push` is high if `oq_full` is low, or `push_stall` is high if `oq_full` is high.
- R3: `oq_push` is never high while `oq_full` is high, and never high without a held push.
- R4: While a held push meets `oq_full` high, `push_stall` is high and `oq_data` stays unchanged. A `push_issue` in such a cycle is ignored: it is neither stored nor pushed later.
- R5: With `oq_full` low and `push_issue` high on every cycle, `oq_push` is high on every cycle. The words come out in issue order.
- R6: When `pop_issue` is high in POP_IDLE and `iq_empty` is low, `iq_pop` is high in that same cycle. `iq_pop` is never high while `iq_empty` is high.
- R7: The word on `iq_data` in a cycle where `iq_pop` is high is loaded into `pop_result`. In the next cycle `pop_valid` is high for exactly one cycle.
- R8: A `pop_issue` while `iq_empty` is high raises `pop_stall` in that cycle. The stall stays up until `iq_empty` falls, and then `iq_pop` is raised in that cycle. A `pop_issue` during the wait is ignored, so exactly one pop takes place.
- R9: During reset the following are low or zero: `oq_push`, `iq_pop`, `push_stall`, `pop_stall`, `pop_valid`, `oq_data` and `pop_result`.
- R10: Push and pop work independently. Both can complete one transfer on every cycle at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_issue | input | 1 | Push instruction issued this cycle |
| push_fn | input | 2 | Selects how the pushed value is formed |
| push_opa | input | W | First operand |
| push_opb | input | W | Second operand |
| push_stall | output | 1 | Outbound transfer blocked by full |
| oq_full | input | 1 | Outbound FIFO is full |
| oq_push | output | 1 | Push request to the outbound FIFO |
| oq_data | output | W | Word offered to the outbound FIFO |
| pop_issue | input | 1 | Pop instruction issued this cycle |
| pop_stall | output | 1 | Inbound transfer blocked by empty |
| iq_empty | input | 1 | Inbound FIFO is empty |
| iq_pop | output | 1 | Pop request to the inbound FIFO |
| iq_data | input | W | Word from the inbound FIFO |
| pop_result | output | W | Result register holding the last popped word |
| pop_valid | output | 1 | One-cycle pulse after a pop |

## Verification
A push state machine stuck in PUSH_HELD shows up one cycle after the last push: `oq_push` fires again, or `push_stall` rises with no new issue. A machine that leaves PUSH_HELD too early drops the word, and `oq_data` changes while a stall is up.

On the pop side, a wrong POP_WAIT state shows up as a stall that does not clear in the same cycle that `iq_empty` falls, or as a second pop caused by an ignored issue. Both are visible within one cycle.

A wrong computed value or a lost result word shows up on `oq_data` or `pop_result` in the first cycle that follows the transfer.

// File: rtl/qport_pkg.sv
package qport_pkg;

    typedef enum logic {
        PUSH_IDLE = 1'b0,
        PUSH_HELD = 1'b1
    } push_state_t;

    typedef enum logic {
        POP_IDLE = 1'b0,
        POP_WAIT = 1'b1
    } pop_state_t;

    typedef enum logic [1:0] {
        FN_PASS   = 2'd0,
        FN_AVG    = 2'd1,
        FN_CLRLOW = 2'd2,
        FN_POPCNT = 2'd3
    } push_fn_t;

endpackage

// File: rtl/qport_push_alu.sv
module qport_push_alu
    import qport_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   fn,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] result
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W:0]   wide_sum;
    logic [W-1:0] ones_cnt;
    logic [W-1:0] clr_low;

    assign wide_sum = {1'b0, opa} + {1'b0, opb};
    assign clr_low  = opa & (opa - ONE);

    always_comb begin
        ones_cnt = '0;
        for (int i = 0; i < W; i++) begin
            ones_cnt = ones_cnt + {{(W-1){1'b0}}, opa[i]};
        end
    end

    always_comb begin
        unique case (push_fn_t'(fn))
            FN_PASS:   result = opa;
            FN_AVG:    result = wide_sum[W:1];
            FN_CLRLOW: result = clr_low;
            FN_POPCNT: result = ones_cnt;
        endcase
    end

endmodule

// File: rtl/qport_push_fsm.sv
module qport_push_fsm
    import qport_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue,
    input  logic [W-1:0] value,
    input  logic         full,
    output logic         push,
    output logic [W-1:0] data,
    output logic         stall
);

    push_state_t state_q;
    push_state_t state_d;
    logic        accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PUSH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        push    = 1'b0;
        stall   = 1'b0;
        unique case (state_q)
            PUSH_IDLE: begin
                accept = issue;
                if (issue) begin
                    state_d = PUSH_HELD;
                end
            end
            PUSH_HELD: begin
                if (full) begin
                    stall = 1'b1;
                end else begin
                    push   = 1'b1;
                    accept = issue;
                    if (!issue) begin
                        state_d = PUSH_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
        end else if (accept) begin
            data <= value;
        end
    end

endmodule

// File: rtl/qport_pop_fsm.sv
module qport_pop_fsm
    import qport_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue,
    input  logic         empty,
    input  logic [W-1:0] din,
    output logic         pop,
    output logic         stall,
    output logic [W-1:0] result,
    output logic         valid
);

    pop_state_t state_q;
    pop_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= POP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pop     = 1'b0;
        stall   = 1'b0;
        unique case (state_q)
            POP_IDLE: begin
                if (issue) begin
                    if (empty) begin
                        stall   = 1'b1;
                        state_d = POP_WAIT;
                    end else begin
                        pop = 1'b1;
                    end
                end
            end
            POP_WAIT: begin
                if (empty) begin
                    stall = 1'b1;
                end else begin
                    pop     = 1'b1;
                    state_d = POP_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= pop;
            if (pop) begin
                result <= din;
            end
        end
    end

endmodule

// File: rtl/qport_bridge.sv
module qport_bridge
    import qport_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_issue,
    input  logic [1:0]   push_fn,
    input  logic [W-1:0] push_opa,
    input  logic [W-1:0] push_opb,
    output logic         push_stall,
    input  logic         oq_full,
    output logic         oq_push,
    output logic [W-1:0] oq_data,
    input  logic         pop_issue,
    output logic         pop_stall,
    input  logic         iq_empty,
    output logic         iq_pop,
    input  logic [W-1:0] iq_data,
    output logic [W-1:0] pop_result,
    output logic         pop_valid
);

    logic [W-1:0] push_value;

    qport_push_alu #(.W(W)) u_alu (
        .fn     (push_fn),
        .opa    (push_opa),
        .opb    (push_opb),
        .result (push_value)
    );

    qport_push_fsm #(.W(W)) u_push (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (push_issue),
        .value (push_value),
        .full  (oq_full),
        .push  (oq_push),
        .data  (oq_data),
        .stall (push_stall)
    );

    qport_pop_fsm #(.W(W)) u_pop (
        .clk    (clk),
        .rst_n  (rst_n),
        .issue  (pop_issue),
        .empty  (iq_empty),
        .din    (iq_data),
        .pop    (iq_pop),
        .stall  (pop_stall),
        .result (pop_result),
        .valid  (pop_valid)
    );

endmodule

// File: rtl/qport_bridge_chk.sv
module qport_bridge_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         push_issue,
    input logic         push_stall,
    input logic         oq_full,
    input logic         oq_push,
    input logic [W-1:0] oq_data,
    input logic         pop_stall,
    input logic         iq_empty,
    input logic         iq_pop,
    input logic [W-1:0] iq_data,
    input logic [W-1:0] pop_result,
    input logic         pop_valid
);

    AST_ACCEPT_THEN_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (push_issue && !push_stall) |=> (oq_push || push_stall)); // R2

    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        oq_push |-> !oq_full); // R3

    AST_STALL_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        push_stall |=> $stable(oq_data)); // R4

    AST_STALL_EXCLUDES_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_stall && oq_push)); // R4

    AST_NO_POP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        iq_pop |-> !iq_empty); // R6

    AST_POP_LOADS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        iq_pop |=> (pop_valid && pop_result == $past(iq_data))); // R7

    AST_VALID_NEEDS_POP: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> $past(iq_pop)); // R7

    AST_POP_STALL_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_stall |-> (iq_empty && !iq_pop)); // R8

endmodule

bind qport_bridge qport_bridge_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_issue (push_issue),
    .push_stall (push_stall),
    .oq_full    (oq_full),
    .oq_push    (oq_push),
    .oq_data    (oq_data),
    .pop_stall  (pop_stall),
    .iq_empty   (iq_empty),
    .iq_pop     (iq_pop),
    .iq_data    (iq_data),
    .pop_result (pop_result),
    .pop_valid  (pop_valid)
);

// File: tb/qport_bridge_bench.sv
`timescale 1ns/100ps
module qport_bridge_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         push_issue = 1'b0;
    logic [1:0]   push_fn = 2'd0;
    logic [W-1:0] push_opa = '0;
    logic [W-1:0] push_opb = '0;
    logic         push_stall;
    logic         oq_full = 1'b0;
    logic         oq_push;
    logic [W-1:0] oq_data;
    logic         pop_issue = 1'b0;
    logic         pop_stall;
    logic         iq_empty = 1'b1;
    logic         iq_pop;
    logic [W-1:0] iq_data = '0;
    logic [W-1:0] pop_result;
    logic         pop_valid;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    qport_bridge #(.W(W)) u_qport_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_issue (push_issue),
        .push_fn    (push_fn),
        .push_opa   (push_opa),
        .push_opb   (push_opb),
        .push_stall (push_stall),
        .oq_full    (oq_full),
        .oq_push    (oq_push),
        .oq_data    (oq_data),
        .pop_issue  (pop_issue),
        .pop_stall  (pop_stall),
        .iq_empty   (iq_empty),
        .iq_pop     (iq_pop),
        .iq_data    (iq_data),
        .pop_result (pop_result),
        .pop_valid  (pop_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int expect_fn(int fn, int a, int b);
        int r;
        int low;
        int x;
        r = 0;
        case (fn)
            0: r = a;
            1: r = (a + b) / 2;
            2: begin
                if (a == 0) begin
                    r = 0;
                end else begin
                    low = 1;
                    while (((a / low) % 2) == 0) low = low * 2;
                    r = a - low;
                end
            end
            default: begin
                x = a;
                while (x > 0) begin
                    r = r + (x % 2);
                    x = x / 2;
                end
            end
        endcase
        return r;
    endfunction

    // R1 R5: one push issued per cycle, each value checked a cycle later
    task automatic push_sweep(input int fn);
        int  prev;
        bit  have;
        int  nb;
        have = 1'b0;
        prev = 0;
        nb = (fn == 1) ? 16 : 1;
        for (int a = 0; a < 256; a++) begin
            for (int bi = 0; bi < nb; bi++) begin
                int b;
                b = (fn == 1) ? bi * 17 : 255 - a;
                @(negedge clk);
                push_issue = 1'b1;
                push_fn    = 2'(fn);
                push_opa   = 8'(a);
                push_opb   = 8'(b);
                oq_full    = 1'b0;
                #1;
                if (have) begin
                    chk(oq_push === 1'b1, "R5", int'(oq_push), 1);
                    chk(int'(oq_data) == prev, "R1", int'(oq_data), prev);
                end
                prev = expect_fn(fn, a, b);
                have = 1'b1;
            end
        end
        @(negedge clk);
        push_issue = 1'b0;
        #1;
        chk(oq_push === 1'b1 && int'(oq_data) == prev, "R2", int'(oq_data), prev);
    endtask

    initial begin
        #1;
        chk(oq_push === 1'b0 && iq_pop === 1'b0, "R9", int'({oq_push, iq_pop}), 0);
        chk(push_stall === 1'b0 && pop_stall === 1'b0, "R9", int'({push_stall, pop_stall}), 0);
        chk(pop_valid === 1'b0, "R9", int'(pop_valid), 0);
        chk(oq_data === '0 && pop_result === '0, "R9", int'(oq_data), 0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int f = 0; f < 4; f++) push_sweep(f);

        // R3 R4: back-pressure holds the word; issue during stall ignored
        @(negedge clk);
        push_issue = 1'b1; push_fn = 2'd0; push_opa = 8'hA5; oq_full = 1'b1;
        #1;
        chk(oq_push === 1'b0, "R3", int'(oq_push), 0);
        @(negedge clk);
        push_opa = 8'h3C;
        #1;
        chk(push_stall === 1'b1 && oq_push === 1'b0, "R4", int'({push_stall, oq_push}), 2);
        chk(int'(oq_data) == 'hA5, "R4", int'(oq_data), 'hA5);
        @(negedge clk);
        push_issue = 1'b0;
        #1;
        chk(push_stall === 1'b1 && int'(oq_data) == 'hA5, "R4", int'(oq_data), 'hA5);
        @(negedge clk);
        oq_full = 1'b0;
        #1;
        chk(oq_push === 1'b1 && push_stall === 1'b0, "R3", int'({oq_push, push_stall}), 2);
        chk(int'(oq_data) == 'hA5, "R4", int'(oq_data), 'hA5);
        @(negedge clk);
        #1;
        chk(oq_push === 1'b0, "R4", int'(oq_push), 0);

        // R6 R7: one pop per cycle over every data value
        begin
            int prev;
            prev = -1;
            for (int d = 0; d < 256; d++) begin
                @(negedge clk);
                pop_issue = 1'b1; iq_empty = 1'b0; iq_data = 8'(d ^ 8'h5A);
                #1;
                chk(iq_pop === 1'b1, "R6", int'(iq_pop), 1);
                if (prev >= 0) begin
                    chk(pop_valid === 1'b1 && int'(pop_result) == prev, "R7", int'(pop_result), prev);
                end
                prev = d ^ 'h5A;
            end
            @(negedge clk);
            pop_issue = 1'b0;
            #1;
            chk(iq_pop === 1'b0 && pop_valid === 1'b1 && int'(pop_result) == prev, "R7", int'(pop_result), prev);
            @(negedge clk);
            #1;
            chk(pop_valid === 1'b0, "R7", int'(pop_valid), 0);
        end

        // R8: pop waits on empty, extra issue ignored
        @(negedge clk);
        pop_issue = 1'b1; iq_empty = 1'b1;
        #1;
        chk(pop_stall === 1'b1 && iq_pop === 1'b0, "R8", int'({pop_stall, iq_pop}), 2);
        chk(iq_pop === 1'b0, "R6", int'(iq_pop), 0);
        @(negedge clk);
        #1;
        chk(pop_stall === 1'b1 && iq_pop === 1'b0, "R8", int'({pop_stall, iq_pop}), 2);
        @(negedge clk);
        pop_issue = 1'b0; iq_empty = 1'b0; iq_data = 8'hC3;
        #1;
        chk(iq_pop === 1'b1 && pop_stall === 1'b0, "R8", int'({iq_pop, pop_stall}), 2);
        @(negedge clk);
        #1;
        chk(iq_pop === 1'b0, "R8", int'(iq_pop), 0);
        chk(pop_valid === 1'b1 && int'(pop_result) == 'hC3, "R7", int'(pop_result), 'hC3);
        @(negedge clk);
        #1;
        chk(pop_valid === 1'b0, "R8", int'(pop_valid), 0);

        // R10: concurrent push and pop every cycle
        begin
            int pexp;
            int qexp;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                push_issue = 1'b1; push_fn = 2'd1; push_opa = 8'(k * 7); push_opb = 8'(k * 13);
                oq_full = 1'b0;
                pop_issue = 1'b1; iq_empty = 1'b0; iq_data = 8'(k * 29);
                #1;
                chk(iq_pop === 1'b1, "R10", int'(iq_pop), 1);
                if (k > 0) begin
                    chk(oq_push === 1'b1 && int'(oq_data) == pexp, "R10", int'(oq_data), pexp);
                    chk(pop_valid === 1'b1 && int'(pop_result) == qexp, "R10", int'(pop_result), qexp);
                end
                pexp = expect_fn(1, (k * 7) % 256, (k * 13) % 256);
                qexp = (k * 29) % 256;
            end
            @(negedge clk);
            push_issue = 1'b0; pop_issue = 1'b0;
            #1;
            chk(int'(oq_data) == pexp && int'(pop_result) == qexp, "R10", int'(oq_data), pexp);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule